// File: doc/BRIEF.md
# Directory Home Controller

This block is the coherence controller at the home node of one slice of distributed shared memory in a four-node machine. The home keeps one directory entry for each of its local blocks. An entry has a dirty flag and a presence mask with one bit per node. A set presence bit means that node may hold a copy of the block. Every read or write miss for a local block reaches the home as a request message. The home performs the coherence work the block needs: it fetches the line back from a dirty owner, or it invalidates the sharers. It then returns the block in a data message and updates its local memory and the directory entry.

Requests enter a fixed-depth wait queue. A single engine handles them one at a time, in arrival order, so a later access to a block only starts once the earlier access has fully completed. Node responses are acknowledgements and returned data, and the home always accepts them. All outgoing traffic uses one valid/ready channel. Message type codes are: 0 read miss, 1 write miss, 2 fetch (the owner keeps a clean copy), 3 fetch-and-invalidate, 4 invalidate, 5 acknowledge, 6 data. The block index is taken from address bits [11:8], so a 256-byte block size gives 16 local blocks. The bits above bit 11 select the home and are not decoded here.

Top module: `dirhome_top`

## Requirements
- R1: After reset, every directory entry is clean with an empty presence mask, `req_ready` is 1 and `out_valid` is 0.
- R2: A read miss from node k to a clean block is answered with a data message (type 6) to node k. The message carries the memory word, which after reset is 0x5EED0000 + 0x111*b for block b. Presence bit k is then set.
- R3: A read miss to a dirty block first sends a fetch (type 2) to the owner. When the owner's data message (type 6) arrives, memory takes that word and the requester receives it. The block becomes clean, and both the owner and the requester are marked present.
- R4: A write miss to a clean block sends an invalidate (type 4) to every other present node, lowest node index first. No reply is sent until an acknowledge (type 5) has arrived for each invalidate. The reply carries the memory word. The entry then becomes dirty with only the requester present.
- R5: A write miss to a dirty block sends a fetch-and-invalidate (type 3) to the owner. Memory takes the returned word, and the requester receives that word. The entry stays dirty with only the requester present.
- R6: Requests are completed one at a time, in the order they were accepted.
- R7: The wait queue holds `QDEPTH` requests. `req_ready` is 0 whenever it is full.
- R8: While `out_valid` is 1 and `out_ready` is 0, every outgoing field holds its value.
- R9: Every outgoing message carries the full address of the request being served. The block is selected by address bits [11:8] only.
- R10: A data message from a node other than the awaited owner is ignored, and so is an acknowledge that arrives while no invalidate is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Queue can take a request |
| req_type | input | 3 | Request type code (0 read, 1 write) |
| req_src | input | 2 | Requesting node |
| req_addr | input | 14 | Request address |
| rsp_valid | input | 1 | Node response present |
| rsp_type | input | 3 | Response type code (5 ack, 6 data) |
| rsp_src | input | 2 | Responding node |
| rsp_data | input | 32 | Returned block word |
| out_valid | output | 1 | Outgoing message present |
| out_ready | input | 1 | Outgoing message taken |
| out_type | output | 3 | Outgoing type code |
| out_dst | output | 2 | Destination node |
| out_addr | output | 14 | Address of the request being served |
| out_data | output | 32 | Block word for data messages, zero otherwise |

## Verification
The bench builds the block with its default values: four nodes, sixteen blocks and a four-entry queue. With four nodes, a write to a block shared by three others produces the longest invalidate chain. Five back-to-back requests held behind a stalled reply are enough to fill the queue. Random traffic is concentrated on a handful of blocks and random home bits, so that reads and writes repeatedly change ownership of the same blocks and address aliasing gets exercised.

// File: rtl/dirhome_pkg.sv
package dirhome_pkg;

  typedef enum logic [2:0] {
    MSG_RD        = 3'd0,
    MSG_WR        = 3'd1,
    MSG_FETCH     = 3'd2,
    MSG_FETCH_INV = 3'd3,
    MSG_INVAL     = 3'd4,
    MSG_ACK       = 3'd5,
    MSG_DATA      = 3'd6
  } msg_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DECIDE, ST_FETCH, ST_WAIT_DATA, ST_INV, ST_WAIT_ACK, ST_REPLY
  } eng_state_t;

  // Memory content of block b right after reset.
  function automatic logic [31:0] seed_word(input int unsigned b);
    return 32'h5EED_0000 + 32'(b) * 32'h111;
  endfunction

endpackage

// File: rtl/dirhome_fifo.sv
module dirhome_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);

  logic [W-1:0]  slot [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign dout  = slot[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) slot[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      count <= count + CW'(push) - CW'(pop);
    end
  end

endmodule

// File: rtl/dirhome_store.sv
module dirhome_store
  import dirhome_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int NBLK   = 16,
  parameter int DATA_W = 32,
  localparam int IW    = $clog2(NBLK)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [IW-1:0]           idx,
  output logic                    rd_dirty,
  output logic [NODES-1:0]        rd_pres,
  output logic [DATA_W-1:0]       rd_data,
  input  logic                    dir_we,
  input  logic                    wr_dirty,
  input  logic [NODES-1:0]        wr_pres,
  input  logic                    mem_we,
  input  logic [DATA_W-1:0]       mem_wdata,
  output logic [NBLK-1:0]         dirty_vec,
  output logic [NBLK*NODES-1:0]   pres_flat
);

  logic              dirty_q [NBLK];
  logic [NODES-1:0]  pres_q  [NBLK];
  logic [DATA_W-1:0] mem_q   [NBLK];

  assign rd_dirty = dirty_q[idx];
  assign rd_pres  = pres_q[idx];
  assign rd_data  = mem_q[idx];

  for (genvar g = 0; g < NBLK; g++) begin : g_flat
    assign dirty_vec[g]                 = dirty_q[g];
    assign pres_flat[g*NODES +: NODES]  = pres_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBLK; i++) begin
        dirty_q[i] <= 1'b0;
        pres_q[i]  <= '0;
        mem_q[i]   <= DATA_W'(seed_word(i));
      end
    end else begin
      if (dir_we) begin
        dirty_q[idx] <= wr_dirty;
        pres_q[idx]  <= wr_pres;
      end
      if (mem_we) mem_q[idx] <= mem_wdata;
    end
  end

endmodule

// File: rtl/dirhome_engine.sv
module dirhome_engine
  import dirhome_pkg::*;
#(
  parameter int NODES   = 4,
  parameter int AW      = 14,
  parameter int BLK_OFS = 8,
  parameter int NBLK    = 16,
  parameter int DATA_W  = 32,
  localparam int NW     = $clog2(NODES),
  localparam int IW     = $clog2(NBLK),
  localparam int CW     = $clog2(NODES + 1),
  localparam int RW     = 3 + NW + AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q_empty,
  input  logic [RW-1:0]     q_head,
  output logic              q_pop,
  input  logic              rsp_valid,
  input  logic [2:0]        rsp_type,
  input  logic [NW-1:0]     rsp_src,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2:0]        out_type,
  output logic [NW-1:0]     out_dst,
  output logic [AW-1:0]     out_addr,
  output logic [DATA_W-1:0] out_data,
  output logic [IW-1:0]     blk_idx,
  input  logic              rd_dirty,
  input  logic [NODES-1:0]  rd_pres,
  input  logic [DATA_W-1:0] rd_data,
  output logic              dir_we,
  output logic              wr_dirty,
  output logic [NODES-1:0]  wr_pres,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              inv_fire,
  output logic              ack_take,
  output logic              reply_fire,
  output logic [CW-1:0]     ack_cnt,
  output logic [NW-1:0]     cur_src
);

  eng_state_t       state;
  logic [2:0]       cur_kind;
  logic [AW-1:0]    cur_addr;
  logic [NW-1:0]    owner;
  logic [NODES-1:0] pend;
  logic [NODES-1:0] src_bit;
  logic [NODES-1:0] others;
  logic [NW-1:0]    inv_dst;
  logic             fire;
  logic             data_take;
  logic             is_wr;

  // Lowest-numbered node whose bit is set in the mask.
  function automatic logic [NW-1:0] first_one(input logic [NODES-1:0] m);
    logic [NW-1:0] r;
    r = '0;
    for (int i = NODES - 1; i >= 0; i--) if (m[i]) r = NW'(i);
    return r;
  endfunction

  assign is_wr     = (cur_kind == MSG_WR);
  assign blk_idx   = cur_addr[BLK_OFS +: IW];
  assign src_bit   = NODES'(1) << cur_src;
  assign others    = rd_pres & ~src_bit;
  assign inv_dst   = first_one(pend);
  assign q_pop     = (state == ST_IDLE) && !q_empty;

  always_comb begin
    out_valid = 1'b0;
    out_type  = MSG_DATA;
    out_dst   = cur_src;
    out_data  = '0;
    unique case (state)
      ST_FETCH: begin
        out_valid = 1'b1;
        out_type  = is_wr ? MSG_FETCH_INV : MSG_FETCH;
        out_dst   = owner;
      end
      ST_INV: begin
        out_valid = 1'b1;
        out_type  = MSG_INVAL;
        out_dst   = inv_dst;
      end
      ST_REPLY: begin
        out_valid = 1'b1;
        out_data  = rd_data;
      end
      default: ;
    endcase
  end

  assign out_addr   = cur_addr;
  assign fire       = out_valid && out_ready;
  assign inv_fire   = fire && (state == ST_INV);
  assign reply_fire = fire && (state == ST_REPLY);
  assign ack_take   = rsp_valid && (rsp_type == MSG_ACK) && (ack_cnt != '0);
  assign data_take  = (state == ST_WAIT_DATA) && rsp_valid &&
                      (rsp_type == MSG_DATA) && (rsp_src == owner);
  assign mem_we     = data_take;
  assign mem_wdata  = rsp_data;
  assign dir_we     = reply_fire;
  assign wr_dirty   = is_wr;
  assign wr_pres    = is_wr ? src_bit : (rd_pres | src_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cur_kind <= '0;
      cur_src  <= '0;
      cur_addr <= '0;
      owner    <= '0;
      pend     <= '0;
      ack_cnt  <= '0;
    end else begin
      ack_cnt <= ack_cnt + CW'(inv_fire) - CW'(ack_take);
      unique case (state)
        ST_IDLE: if (!q_empty) begin
          {cur_kind, cur_src, cur_addr} <= q_head;
          state <= ST_DECIDE;
        end
        ST_DECIDE: begin
          if (rd_dirty) begin
            owner <= first_one(rd_pres);
            state <= ST_FETCH;
          end else if (is_wr && (others != '0)) begin
            pend  <= others;
            state <= ST_INV;
          end else begin
            state <= ST_REPLY;
          end
        end
        ST_FETCH:     if (fire) state <= ST_WAIT_DATA;
        ST_WAIT_DATA: if (data_take) state <= ST_REPLY;
        ST_INV: if (fire) begin
          pend[inv_dst] <= 1'b0;
          if ((pend & ~(NODES'(1) << inv_dst)) == '0) state <= ST_WAIT_ACK;
        end
        ST_WAIT_ACK:  if (ack_cnt == '0) state <= ST_REPLY;
        ST_REPLY:     if (fire) state <= ST_IDLE;
        default:      state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dirhome_top.sv
module dirhome_top
  import dirhome_pkg::*;
#(
  parameter int NODES   = 4,
  parameter int AW      = 14,
  parameter int BLK_OFS = 8,
  parameter int NBLK    = 16,
  parameter int DATA_W  = 32,
  parameter int QDEPTH  = 4,
  localparam int NW     = $clog2(NODES),
  localparam int IW     = $clog2(NBLK),
  localparam int CW     = $clog2(NODES + 1),
  localparam int QCW    = $clog2(QDEPTH + 1),
  localparam int RW     = 3 + NW + AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_type,
  input  logic [NW-1:0]     req_src,
  input  logic [AW-1:0]     req_addr,
  input  logic              rsp_valid,
  input  logic [2:0]        rsp_type,
  input  logic [NW-1:0]     rsp_src,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2:0]        out_type,
  output logic [NW-1:0]     out_dst,
  output logic [AW-1:0]     out_addr,
  output logic [DATA_W-1:0] out_data
);

  logic                  q_full, q_empty, q_pop, q_push;
  logic [QCW-1:0]        q_count;
  logic [RW-1:0]         q_head;
  logic [IW-1:0]         blk_idx;
  logic                  rd_dirty, dir_we, wr_dirty, mem_we;
  logic [NODES-1:0]      rd_pres, wr_pres;
  logic [DATA_W-1:0]     rd_data, mem_wdata;
  logic                  inv_fire, ack_take, reply_fire;
  logic [CW-1:0]         ack_cnt;
  logic [NW-1:0]         cur_src;
  logic [NBLK-1:0]       dir_dirty_vec;
  logic [NBLK*NODES-1:0] dir_pres_flat;

  assign req_ready = !q_full;
  assign q_push    = req_valid && req_ready;

  dirhome_fifo #(.W(RW), .DEPTH(QDEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n), .push(q_push), .din({req_type, req_src, req_addr}),
    .pop(q_pop), .dout(q_head), .empty(q_empty), .full(q_full), .count(q_count)
  );

  dirhome_store #(.NODES(NODES), .NBLK(NBLK), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .idx(blk_idx), .rd_dirty(rd_dirty), .rd_pres(rd_pres),
    .rd_data(rd_data), .dir_we(dir_we), .wr_dirty(wr_dirty), .wr_pres(wr_pres),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .dirty_vec(dir_dirty_vec),
    .pres_flat(dir_pres_flat)
  );

  dirhome_engine #(.NODES(NODES), .AW(AW), .BLK_OFS(BLK_OFS), .NBLK(NBLK),
                   .DATA_W(DATA_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .q_empty(q_empty), .q_head(q_head), .q_pop(q_pop),
    .rsp_valid(rsp_valid), .rsp_type(rsp_type), .rsp_src(rsp_src), .rsp_data(rsp_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_type(out_type), .out_dst(out_dst),
    .out_addr(out_addr), .out_data(out_data), .blk_idx(blk_idx), .rd_dirty(rd_dirty),
    .rd_pres(rd_pres), .rd_data(rd_data), .dir_we(dir_we), .wr_dirty(wr_dirty),
    .wr_pres(wr_pres), .mem_we(mem_we), .mem_wdata(mem_wdata), .inv_fire(inv_fire),
    .ack_take(ack_take), .reply_fire(reply_fire), .ack_cnt(ack_cnt), .cur_src(cur_src)
  );

endmodule

// File: rtl/dirhome_checker.sv
module dirhome_checker #(
  parameter int NODES  = 4,
  parameter int NBLK   = 16,
  parameter int AW     = 14,
  parameter int DATA_W = 32,
  parameter int QDEPTH = 4,
  localparam int NW    = $clog2(NODES),
  localparam int CW    = $clog2(NODES + 1),
  localparam int QCW   = $clog2(QDEPTH + 1)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_ready,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [2:0]            out_type,
  input logic [NW-1:0]         out_dst,
  input logic [AW-1:0]         out_addr,
  input logic [DATA_W-1:0]     out_data,
  input logic [QCW-1:0]        q_count,
  input logic [CW-1:0]         ack_cnt,
  input logic [NW-1:0]         cur_src,
  input logic [NBLK-1:0]       dir_dirty_vec,
  input logic [NBLK*NODES-1:0] dir_pres_flat
);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_type) && $stable(out_dst)
                                && $stable(out_addr) && $stable(out_data));

  assert_full_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (q_count == QCW'(QDEPTH)) |-> !req_ready);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= QCW'(QDEPTH));

  assert_reply_after_acks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_type == 3'd6) |-> (ack_cnt == '0));

  assert_no_self_inval_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_type == 3'd4) |-> (out_dst != cur_src));

  for (genvar g = 0; g < NBLK; g++) begin : g_own
    assert_single_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
      dir_dirty_vec[g] |-> $onehot(dir_pres_flat[g*NODES +: NODES]));
  end

endmodule

bind dirhome_top dirhome_checker #(
  .NODES(NODES), .NBLK(NBLK), .AW(AW), .DATA_W(DATA_W), .QDEPTH(QDEPTH)
) i_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_type(out_type), .out_dst(out_dst), .out_addr(out_addr),
  .out_data(out_data), .q_count(q_count), .ack_cnt(ack_cnt), .cur_src(cur_src),
  .dir_dirty_vec(dir_dirty_vec), .dir_pres_flat(dir_pres_flat)
);

// File: tb/test_dirhome_top.sv
`timescale 1ns/1ps
module test_dirhome_top;

  localparam int NODES = 4, AW = 14, BLK_OFS = 8, NBLK = 16, DATA_W = 32, QDEPTH = 4;
  localparam int NW = 2;

  logic              clk, rst_n;
  logic              req_valid, req_ready;
  logic [2:0]        req_type;
  logic [NW-1:0]     req_src;
  logic [AW-1:0]     req_addr;
  logic              rsp_valid;
  logic [2:0]        rsp_type;
  logic [NW-1:0]     rsp_src;
  logic [DATA_W-1:0] rsp_data;
  logic              out_valid, out_ready;
  logic [2:0]        out_type;
  logic [NW-1:0]     out_dst;
  logic [AW-1:0]     out_addr;
  logic [DATA_W-1:0] out_data;

  dirhome_top #(.NODES(NODES), .AW(AW), .BLK_OFS(BLK_OFS), .NBLK(NBLK),
                .DATA_W(DATA_W), .QDEPTH(QDEPTH)) i_dirhome_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_type(req_type), .req_src(req_src), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_type(rsp_type), .rsp_src(rsp_src), .rsp_data(rsp_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_type(out_type),
    .out_dst(out_dst), .out_addr(out_addr), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int nvec = 0, nmis = 0;
  string ctx = "";

  bit               mdirty [NBLK];
  logic [NODES-1:0] mpres  [NBLK];
  logic [31:0]      mmem   [NBLK];
  logic [2:0]       qt [64];
  int               qs [64];
  logic [AW-1:0]    qa [64];
  int               qh = 0, qtl = 0;
  bit               stray_en = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nmis++;
      $display("FAIL %s [%s] actual=%h expected=%h", tag, ctx, act, exp);
    end
  endtask

  function automatic logic [31:0] boot_word(input int b);
    return 32'h5EED0000 + 32'(b) * 32'h111;
  endfunction

  function automatic int first_node(input logic [NODES-1:0] m);
    for (int i = 0; i < NODES; i++) if (m[i]) return i;
    return 0;
  endfunction

  function automatic logic [AW-1:0] mkaddr(input int b);
    return {2'($urandom), 4'(b), 8'($urandom)};
  endfunction

  task automatic issue(input logic [2:0] t, input int s, input logic [AW-1:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_type = t; req_src = NW'(s); req_addr = a;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1 req_valid = 1'b0;
    qt[qtl] = t; qs[qtl] = s; qa[qtl] = a; qtl = (qtl + 1) % 64;
  endtask

  task automatic send_rsp(input logic [2:0] t, input int s, input logic [31:0] d);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_type = t; rsp_src = NW'(s); rsp_data = d;
    @(posedge clk); #1 rsp_valid = 1'b0;
  endtask

  task automatic expect_msg(input string tag, input logic [2:0] et, input int ed,
                            input logic [AW-1:0] ea, input logic [31:0] edat);
    logic [2:0] t; logic [NW-1:0] d; logic [AW-1:0] a; logic [31:0] dat;
    @(negedge clk);
    while (!out_valid) @(negedge clk);
    t = out_type; d = out_dst; a = out_addr; dat = out_data;
    repeat ($urandom_range(0, 2)) begin
      @(negedge clk);
      chk("R8 fields held under back-pressure", {out_valid, out_type, out_dst, out_addr, out_data},
          {1'b1, t, d, a, dat});
    end
    out_ready = 1'b1; @(posedge clk); #1 out_ready = 1'b0;
    chk(tag, {t, d, a, (et == 3'd6) ? dat : 32'd0}, {et, NW'(ed), ea, (et == 3'd6) ? edat : 32'd0});
  endtask

  task automatic serve_one();
    logic [2:0] t; int s; logic [AW-1:0] a; int b; int own;
    logic [NODES-1:0] sb, inv; logic [31:0] v;
    t = qt[qh]; s = qs[qh]; a = qa[qh]; qh = (qh + 1) % 64;
    b = int'(a[11:8]); sb = NODES'(1) << s;
    if (mdirty[b]) begin
      own = first_node(mpres[b]);
      if (t == 3'd1) expect_msg("R5 fetch-invalidate to owner, R9 address", 3'd3, own, a, 0);
      else           expect_msg("R3 fetch to owner, R9 address", 3'd2, own, a, 0);
      v = $urandom;
      if (stray_en) send_rsp(3'd6, (own + 1) % NODES, ~v);   // R10 stray data
      send_rsp(3'd6, own, v);
      mmem[b] = v;
      if (t == 3'd1) begin
        expect_msg("R5 reply carries owner data", 3'd6, s, a, v);
        mpres[b] = sb;
      end else begin
        expect_msg("R3 reply carries owner data (R10 stray ignored)", 3'd6, s, a, v);
        mdirty[b] = 0; mpres[b] = mpres[b] | sb;
      end
    end else if (t == 3'd1) begin
      inv = mpres[b] & ~sb;
      for (int i = 0; i < NODES; i++)
        if (inv[i]) expect_msg("R4 invalidate order", 3'd4, i, a, 0);
      if (inv != '0) begin
        repeat (3) begin
          @(negedge clk);
          chk("R4 no reply before acks", {63'd0, out_valid}, 64'd0);
        end
        for (int i = 0; i < NODES; i++) if (inv[i]) send_rsp(3'd5, i, 0);
      end
      expect_msg("R4 write reply", 3'd6, s, a, mmem[b]);
      mdirty[b] = 1; mpres[b] = sb;
    end else begin
      expect_msg("R2 clean read reply", 3'd6, s, a, mmem[b]);
      mpres[b] = mpres[b] | sb;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    nmis++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
    $finish;
  end

  initial begin
    void'($urandom(32'd20111027));
    rst_n = 0; req_valid = 0; req_type = 0; req_src = 0; req_addr = 0;
    rsp_valid = 0; rsp_type = 0; rsp_src = 0; rsp_data = 0; out_ready = 0;
    for (int b = 0; b < NBLK; b++) begin mdirty[b] = 0; mpres[b] = '0; mmem[b] = boot_word(b); end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 reset ready", {63'd0, req_ready}, 64'd1);
    chk("R1 reset idle output", {63'd0, out_valid}, 64'd0);

    // Ownership walk on one block across nodes 1..3.
    ctx = "directed walk";
    issue(3'd0, 1, mkaddr(0)); serve_one();
    issue(3'd1, 2, mkaddr(0)); serve_one();
    issue(3'd0, 3, mkaddr(0)); serve_one();
    issue(3'd1, 1, mkaddr(0)); serve_one();
    issue(3'd1, 2, mkaddr(0)); serve_one();
    issue(3'd0, 3, mkaddr(0)); serve_one();

    // R4: three sharers invalidated by a fourth writer.
    ctx = "R4 wide invalidate";
    for (int n = 1; n < NODES; n++) begin issue(3'd0, n, mkaddr(3)); serve_one(); end
    issue(3'd1, 0, mkaddr(3)); serve_one();

    // R9: different home bits and offsets alias to block 7.
    ctx = "R9 aliasing";
    issue(3'd1, 1, {2'd3, 4'd7, 8'h00}); serve_one();
    issue(3'd0, 2, {2'd0, 4'd7, 8'hFC}); serve_one();

    // R10: acknowledge with nothing outstanding.
    ctx = "R10 idle ack";
    send_rsp(3'd5, 0, 0);
    repeat (3) begin
      @(negedge clk);
      chk("R10 idle ack has no effect", {63'd0, out_valid}, 64'd0);
    end
    issue(3'd0, 0, mkaddr(7)); serve_one();

    // R6/R7: fill the queue behind a stalled reply.
    ctx = "R6 R7 queue";
    issue(3'd0, 2, mkaddr(5));
    repeat (3) @(negedge clk);
    for (int k = 0; k < QDEPTH; k++) issue(3'd0, k % NODES, mkaddr(8 + k));
    @(negedge clk);
    chk("R7 ready low when queue full", {63'd0, req_ready}, 64'd0);
    chk("R6 first accepted served first", {59'd0, out_valid, out_type, out_dst}, {59'd0, 1'b1, 3'd6, 2'd2});
    for (int k = 0; k <= QDEPTH; k++) serve_one();

    // Random traffic on a few hot blocks.
    ctx = "random";
    for (int it = 0; it < 400; it++) begin
      int nq;
      stray_en = ($urandom_range(0, 3) == 0);
      nq = ($urandom_range(0, 4) == 0) ? 2 : 1;
      for (int j = 0; j < nq; j++)
        issue(3'($urandom_range(0, 1)), $urandom_range(0, NODES - 1),
              mkaddr(($urandom_range(0, 5) == 0) ? $urandom_range(0, NBLK - 1) : $urandom_range(0, 3)));
      for (int j = 0; j < nq; j++) serve_one();
    end

    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
    $finish;
  end

endmodule